// File: doc/BRIEF.md
# Chipset Configuration Bank with Upper-Memory Shadow Decoder

This block is the configuration core of a 486-class system controller. Software reaches it through two adjacent I/O bytes: the even byte holds an 8-bit pointer, and the odd byte reads or writes the configuration byte that the pointer selects, out of a bank of 256. A few of those bytes drive sideband controls toward the rest of the chip. These controls are an alternate gate-A20 enable, a memory relocation size, a CPU wait-state count and an external cache enable.

The same bank holds the shadow enables for the upper-memory window C0000h–FFFFFh. Every CPU memory access is decoded from its 20-bit address and the current enables. A read or write in the window is routed either to internal DRAM or to the external bus. The C- and D-pages are split into 16 KB slices, and the E- and F-pages are whole 64 KB blocks. Accesses below C0000h always go to internal DRAM. The decode is combinational, so a new enable applies from the first access after the clock edge that stores it.

Top module: `cfg_shadow_ctl`

## Requirements
- R1: A write to the even port (io_addr0=0) loads the pointer, and a read of the even port returns it. A write to the odd port (io_addr0=1) stores io_wdata into the byte the pointer selects, and a read of the odd port returns that byte. All 256 pointer values address distinct bytes.
- R2: A read of byte 00h through the odd port always returns bit 6 as 1, whatever was stored. After reset, byte 00h holds 40h, byte 02h holds 0Ch, byte 40h holds 08h, and every other byte and the pointer hold 0.
- R3: a20_alt equals bit 0 of byte 01h. It changes on the clock edge that stores the byte.
- R4: Bytes 2Eh and 2Fh hold eight 16 KB slices starting at C0000h and D0000h. Slice k of a byte uses bits 2k+1 and 2k, with k = address bits 15:14. Bit 2k+1 set routes reads of the slice to internal DRAM, and bit 2k set routes writes of the slice to internal DRAM.
- R5: Byte 30h bit 7 (read) and bit 6 (write) control E0000h–EFFFFh. Byte 31h bit 7 (read) and bit 6 (write) control F0000h–FFFFFh. The other bits of these bytes have no effect on the decode.
- R6: In the window, a clear enable routes the access to the external bus (rd_ext/wr_ext). Outside the window, both reads and writes go to internal DRAM. rd_int and rd_ext are both 0 when mem_rd is 0 and exactly one is 1 when mem_rd is 1. The same holds for wr_int/wr_ext and mem_wr.
- R7: reloc_sel encodes byte 2Dh bits 7:6. The value 10 gives 1 (256 KB) and 11 gives 2 (384 KB). The values 01 and 00 give 0 (none).
- R8: wait_states encodes byte 33h bits {3,0}. The value 00 gives 0, 10 gives 1 and 11 gives 2. The value 01 also gives 0. Other bits have no effect.
- R9: ext_cache_en is the inverse of byte 40h bit 3, so it is 0 after reset.
- R10: A shadow-byte write and a memory access in the same cycle decode with the old enables. The new enables apply from the next cycle.
- R11: io_rdata is 0 whenever io_rd is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr0 | input | 1 | I/O address bit 0: 0 selects the pointer, 1 selects the data byte |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 8 | I/O read data, 0 when not reading |
| mem_addr | input | 20 | CPU memory address |
| mem_rd | input | 1 | Memory read qualifier |
| mem_wr | input | 1 | Memory write qualifier |
| rd_int | output | 1 | Read goes to internal DRAM |
| rd_ext | output | 1 | Read goes to the external bus |
| wr_int | output | 1 | Write goes to internal DRAM |
| wr_ext | output | 1 | Write goes to the external bus |
| a20_alt | output | 1 | Alternate gate-A20 enable |
| reloc_sel | output | 2 | Relocation size: 0 none, 1 256 KB, 2 384 KB |
| wait_states | output | 2 | CPU wait states, 0 to 2 |
| ext_cache_en | output | 1 | External cache enable, active high |

## Verification
A write to a shadow byte through the odd port and a memory access that hits the slice it controls can fall in the same cycle. The bench provokes this by raising io_wr with the pointer at 2Eh while presenting a read of C0000h. It checks that the route is external in that cycle, because the old enable is still in force. It then checks that the route is internal in the following cycle, once the edge has stored the new byte.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;

  localparam logic [7:0] IDX_STATUS = 8'h00;
  localparam logic [7:0] IDX_A20    = 8'h01;
  localparam logic [7:0] IDX_BUSCLK = 8'h02;
  localparam logic [7:0] IDX_RELOC  = 8'h2D;
  localparam logic [7:0] IDX_SHC    = 8'h2E;
  localparam logic [7:0] IDX_SHD    = 8'h2F;
  localparam logic [7:0] IDX_SHE    = 8'h30;
  localparam logic [7:0] IDX_SHF    = 8'h31;
  localparam logic [7:0] IDX_WAIT   = 8'h33;
  localparam logic [7:0] IDX_CACHE  = 8'h40;

  localparam logic [7:0] STATUS_FORCE = 8'h40;
  localparam logic [3:0] SLOT_NONE    = 4'hF;

  typedef enum logic [1:0] {
    RELOC_NONE = 2'd0,
    RELOC_256K = 2'd1,
    RELOC_384K = 2'd2
  } reloc_e;

  // Value a configuration byte takes at reset.
  function automatic logic [7:0] reset_value(input logic [7:0] idx);
    case (idx)
      IDX_STATUS: reset_value = 8'h40;
      IDX_BUSCLK: reset_value = 8'h0C;
      IDX_CACHE:  reset_value = 8'h08;
      default:    reset_value = 8'h00;
    endcase
  endfunction

  // {bit7, bit6} of the relocation byte -> size code.
  function automatic reloc_e reloc_decode(input logic [1:0] hi2);
    case (hi2)
      2'b10:   reloc_decode = RELOC_256K;
      2'b11:   reloc_decode = RELOC_384K;
      default: reloc_decode = RELOC_NONE;
    endcase
  endfunction

  // Bit 3 and bit 0 of the wait byte -> wait-state count.
  function automatic logic [1:0] wait_decode(input logic b3, input logic b0);
    if (!b3)     wait_decode = 2'd0;
    else if (b0) wait_decode = 2'd2;
    else         wait_decode = 2'd1;
  endfunction

  // Address bits 19:14 -> shadow slot 0..9, or SLOT_NONE below C0000h.
  function automatic logic [3:0] seg_slot(input logic [5:0] page);
    if (page[5:4] != 2'b11)       seg_slot = SLOT_NONE;
    else if (page[3:2] == 2'b00)  seg_slot = {2'b00, page[1:0]};
    else if (page[3:2] == 2'b01)  seg_slot = {2'b01, page[1:0]};
    else if (page[3:2] == 2'b10)  seg_slot = 4'd8;
    else                          seg_slot = 4'd9;
  endfunction

endpackage

// File: rtl/cfg_regbank.sv
module cfg_regbank
  import cfg_shadow_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_addr0,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  output logic [IDX_W-1:0]  cur_index,
  output logic              a20_bit,
  output logic [1:0]        reloc_bits,
  output logic [1:0]        ws_bits,
  output logic              cache_n,
  output logic [19:0]       shadow_en
);

  localparam int NREG = 1 << IDX_W;

  logic [IDX_W-1:0]             idx_q;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;
  logic                         index_wr_evt;
  logic                         data_wr_evt;
  logic [DATA_W-1:0]            sel_byte;
  logic [DATA_W-1:0]            rd_val;

  assign index_wr_evt = io_wr & ~io_addr0;
  assign data_wr_evt  = io_wr &  io_addr0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NREG; i++) regs_q[i] <= reset_value(8'(i));
    end else if (index_wr_evt) begin
      idx_q <= io_wdata[IDX_W-1:0];
    end else if (data_wr_evt) begin
      regs_q[idx_q] <= io_wdata;
    end
  end

  assign sel_byte = regs_q[idx_q];

  always_comb begin
    if (!io_addr0)                      rd_val = DATA_W'(idx_q);
    else if (idx_q == IDX_W'(IDX_STATUS)) rd_val = sel_byte | STATUS_FORCE;
    else                                rd_val = sel_byte;
  end

  assign io_rdata  = io_rd ? rd_val : '0;
  assign cur_index = idx_q;

  assign a20_bit    = regs_q[IDX_A20][0];
  assign reloc_bits = regs_q[IDX_RELOC][7:6];
  assign ws_bits    = {regs_q[IDX_WAIT][3], regs_q[IDX_WAIT][0]};
  assign cache_n    = regs_q[IDX_CACHE][3];
  assign shadow_en  = {regs_q[IDX_SHF][7:6], regs_q[IDX_SHE][7:6],
                       regs_q[IDX_SHD], regs_q[IDX_SHC]};

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    index_wr_evt |=> idx_q == $past(io_wdata[IDX_W-1:0]));

  // R1
  data_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_evt |=> regs_q[$past(idx_q)] == $past(io_wdata));

  // R2
  cache_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr0 && idx_q == IDX_W'(IDX_STATUS)) |-> io_rdata[6]);

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == '0);

endmodule

// File: rtl/cfg_sideband.sv
module cfg_sideband
  import cfg_shadow_pkg::*;
(
  input  logic       a20_bit,
  input  logic [1:0] reloc_bits,
  input  logic [1:0] ws_bits,
  input  logic       cache_n,
  output logic       a20_alt,
  output reloc_e     reloc_sel,
  output logic [1:0] wait_states,
  output logic       ext_cache_en
);

  assign a20_alt      = a20_bit;
  assign reloc_sel    = reloc_decode(reloc_bits);
  assign wait_states  = wait_decode(ws_bits[1], ws_bits[0]);
  assign ext_cache_en = ~cache_n;

endmodule

// File: rtl/shadow_decode.sv
module shadow_decode
  import cfg_shadow_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NSLOT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [2*NSLOT-1:0] shadow_en,
  output logic              rd_int,
  output logic              rd_ext,
  output logic              wr_int,
  output logic              wr_ext
);

  localparam int PAGE_LO = ADDR_W - 6;

  logic [5:0]       page;
  logic [3:0]       slot;
  logic             in_window;
  logic [NSLOT-1:0] slot_rd_en;
  logic [NSLOT-1:0] slot_wr_en;
  logic [NSLOT-1:0] slot_hit;
  logic             rd_flag;
  logic             wr_flag;
  logic             unused_low;

  assign page       = mem_addr[ADDR_W-1:PAGE_LO];
  assign unused_low = ^mem_addr[PAGE_LO-1:0];
  assign slot       = seg_slot(page);
  assign in_window  = (slot != SLOT_NONE);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_rd_en[g] = shadow_en[2*g+1];
    assign slot_wr_en[g] = shadow_en[2*g];
    assign slot_hit[g]   = in_window && (slot == 4'(g));
  end

  assign rd_flag = !in_window || |(slot_hit & slot_rd_en);
  assign wr_flag = !in_window || |(slot_hit & slot_wr_en);

  assign rd_int = mem_rd &  rd_flag;
  assign rd_ext = mem_rd & ~rd_flag;
  assign wr_int = mem_wr &  wr_flag;
  assign wr_ext = mem_wr & ~wr_flag;

  // R6
  outside_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wr && page[5:4] != 2'b11) |-> (rd_int && wr_int));

  // R6
  route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_int, rd_ext}) && $onehot0({wr_int, wr_ext}) &&
    ((rd_int | rd_ext) == mem_rd) && ((wr_int | wr_ext) == mem_wr));

endmodule

// File: rtl/cfg_shadow_ctl.sv
module cfg_shadow_ctl
  import cfg_shadow_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_addr0,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  output logic              rd_int,
  output logic              rd_ext,
  output logic              wr_int,
  output logic              wr_ext,
  output logic              a20_alt,
  output logic [1:0]        reloc_sel,
  output logic [1:0]        wait_states,
  output logic              ext_cache_en
);

  localparam int NSLOT = 10;

  logic [IDX_W-1:0]   cur_index;
  logic               a20_bit;
  logic [1:0]         reloc_bits;
  logic [1:0]         ws_bits;
  logic               cache_n;
  logic [2*NSLOT-1:0] shadow_en;
  reloc_e             reloc_code;
  logic               cfg_wr_evt;

  cfg_regbank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_addr0   (io_addr0),
    .io_wdata   (io_wdata),
    .io_rd      (io_rd),
    .io_wr      (io_wr),
    .io_rdata   (io_rdata),
    .cur_index  (cur_index),
    .a20_bit    (a20_bit),
    .reloc_bits (reloc_bits),
    .ws_bits    (ws_bits),
    .cache_n    (cache_n),
    .shadow_en  (shadow_en)
  );

  cfg_sideband u_side (
    .a20_bit      (a20_bit),
    .reloc_bits   (reloc_bits),
    .ws_bits      (ws_bits),
    .cache_n      (cache_n),
    .a20_alt      (a20_alt),
    .reloc_sel    (reloc_code),
    .wait_states  (wait_states),
    .ext_cache_en (ext_cache_en)
  );

  assign reloc_sel = reloc_code;

  shadow_decode #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .shadow_en (shadow_en),
    .rd_int    (rd_int),
    .rd_ext    (rd_ext),
    .wr_int    (wr_int),
    .wr_ext    (wr_ext)
  );

  assign cfg_wr_evt = io_wr & io_addr0;

  // R3
  a20_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_evt && cur_index == IDX_W'(IDX_A20)) |=> a20_alt == $past(io_wdata[0]));

  // R7
  reloc_lone6_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_evt && cur_index == IDX_W'(IDX_RELOC) && !io_wdata[7]) |=> reloc_sel == 2'd0);

  // R8
  wait_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_evt && cur_index == IDX_W'(IDX_WAIT) && !io_wdata[3]) |=> wait_states == 2'd0);

  // R9
  cache_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_evt && cur_index == IDX_W'(IDX_CACHE)) |=> ext_cache_en == !$past(io_wdata[3]));

endmodule

// File: tb/sim_cfg_shadow_ctl.sv
module sim_cfg_shadow_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_addr0 = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = 20'h0;
  logic        mem_rd = 1'b0;
  logic        mem_wr = 1'b0;
  logic        rd_int, rd_ext, wr_int, wr_ext;
  logic        a20_alt;
  logic [1:0]  reloc_sel;
  logic [1:0]  wait_states;
  logic        ext_cache_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  cfg_shadow_ctl u0 (
    .clk(clk), .rst_n(rst_n), .io_addr0(io_addr0), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .rd_int(rd_int), .rd_ext(rd_ext),
    .wr_int(wr_int), .wr_ext(wr_ext), .a20_alt(a20_alt), .reloc_sel(reloc_sel),
    .wait_states(wait_states), .ext_cache_en(ext_cache_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_put(input logic a0, input logic [7:0] d);
    @(negedge clk);
    io_addr0 = a0; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
    io_put(1'b0, idx);
    io_put(1'b1, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
    io_put(1'b0, idx);
    @(negedge clk);
    io_addr0 = 1'b1; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  // Checks the route of a read and then a write at one address.
  task automatic probe(input logic [19:0] a, input logic exp_r, input logic exp_w, input string req);
    @(negedge clk);
    mem_addr = a; mem_rd = 1'b1; mem_wr = 1'b0;
    #1;
    check({req, " read route"}, {30'd0, rd_int, rd_ext}, {30'd0, exp_r, !exp_r});
    check({req, " idle write"}, {30'd0, wr_int, wr_ext}, 32'd0);
    mem_rd = 1'b0; mem_wr = 1'b1;
    #1;
    check({req, " write route"}, {30'd0, wr_int, wr_ext}, {30'd0, exp_w, !exp_w});
    check({req, " idle read"}, {30'd0, rd_int, rd_ext}, 32'd0);
    mem_wr = 1'b0;
  endtask

  task automatic test_reset();
    logic [7:0] d;
    check("R2 a20 reset", {31'd0, a20_alt}, 32'd0);
    check("R9 cache reset", {31'd0, ext_cache_en}, 32'd0);
    check("R7 reloc reset", {30'd0, reloc_sel}, 32'd0);
    check("R8 wait reset", {30'd0, wait_states}, 32'd0);
    @(negedge clk); io_addr0 = 1'b0; io_rd = 1'b1; #1 d = io_rdata; io_rd = 1'b0;
    check("R2 pointer reset", {24'd0, d}, 32'd0);
    reg_read(8'h00, d); check("R2 byte00 reset", {24'd0, d}, 32'h40);
    reg_read(8'h02, d); check("R2 byte02 reset", {24'd0, d}, 32'h0C);
    reg_read(8'h40, d); check("R2 byte40 reset", {24'd0, d}, 32'h08);
    reg_read(8'h7F, d); check("R2 byte7F reset", {24'd0, d}, 32'h00);
    probe(20'hC0000, 1'b0, 1'b0, "R6 reset window");
  endtask

  task automatic test_index_data();
    logic [7:0] d;
    io_put(1'b0, 8'h5A);
    @(negedge clk); io_addr0 = 1'b0; io_rd = 1'b1; #1 d = io_rdata; io_rd = 1'b0;
    check("R1 pointer readback", {24'd0, d}, 32'h5A);
    reg_write(8'hFF, 8'h99);
    reg_write(8'hFE, 8'h11);
    reg_read(8'hFF, d); check("R1 byte FF", {24'd0, d}, 32'h99);
    reg_read(8'hFE, d); check("R1 byte FE", {24'd0, d}, 32'h11);
  endtask

  task automatic test_status();
    logic [7:0] d;
    reg_write(8'h00, 8'h00);
    reg_read(8'h00, d); check("R2 forced bit6 on 00", {24'd0, d}, 32'h40);
    reg_write(8'h00, 8'h81);
    reg_read(8'h00, d); check("R2 forced bit6 on 81", {24'd0, d}, 32'hC1);
  endtask

  task automatic test_idle_bus();
    @(negedge clk);
    io_addr0 = 1'b1; io_rd = 1'b0;
    #1 check("R11 rdata idle", {24'd0, io_rdata}, 32'd0);
  endtask

  task automatic test_a20();
    reg_write(8'h01, 8'h01);
    check("R3 a20 set", {31'd0, a20_alt}, 32'd1);
    reg_write(8'h01, 8'hFE);
    check("R3 a20 clear", {31'd0, a20_alt}, 32'd0);
  endtask

  task automatic test_small_slices();
    // 2Eh = 9C: slice0 none, slice1 both, slice2 write only, slice3 read only
    reg_write(8'h2E, 8'h9C);
    // 2Fh = 63: slice0 both, slice1 none, slice2 read only, slice3 write only
    reg_write(8'h2F, 8'h63);
    probe(20'hC0000, 1'b0, 1'b0, "R4 C0000");
    probe(20'hC7FFF, 1'b1, 1'b1, "R4 C7FFF");
    probe(20'hC8000, 1'b0, 1'b1, "R4 C8000");
    probe(20'hCC010, 1'b1, 1'b0, "R4 CC010");
    probe(20'hD0000, 1'b1, 1'b1, "R4 D0000");
    probe(20'hD4000, 1'b0, 1'b0, "R4 D4000");
    probe(20'hDBFFF, 1'b1, 1'b0, "R4 DBFFF");
    probe(20'hDC000, 1'b0, 1'b1, "R4 DC000");
  endtask

  task automatic test_large_blocks();
    reg_write(8'h30, 8'h80);
    reg_write(8'h31, 8'h40);
    probe(20'hE8000, 1'b1, 1'b0, "R5 E8000");
    probe(20'hFFFF0, 1'b0, 1'b1, "R5 FFFF0");
    reg_write(8'h30, 8'h3F);
    probe(20'hE0000, 1'b0, 1'b0, "R5 E low bits ignored");
  endtask

  task automatic test_outside();
    probe(20'h9FFFF, 1'b1, 1'b1, "R6 9FFFF");
    probe(20'h00000, 1'b1, 1'b1, "R6 00000");
    probe(20'hBC000, 1'b1, 1'b1, "R6 BC000");
  endtask

  task automatic test_reloc();
    reg_write(8'h2D, 8'h80); check("R7 reloc 10", {30'd0, reloc_sel}, 32'd1);
    reg_write(8'h2D, 8'hC0); check("R7 reloc 11", {30'd0, reloc_sel}, 32'd2);
    reg_write(8'h2D, 8'h40); check("R7 reloc 01", {30'd0, reloc_sel}, 32'd0);
    reg_write(8'h2D, 8'hBF); check("R7 reloc 10 low set", {30'd0, reloc_sel}, 32'd1);
    reg_write(8'h2D, 8'h00); check("R7 reloc 00", {30'd0, reloc_sel}, 32'd0);
  endtask

  task automatic test_wait();
    reg_write(8'h33, 8'h08); check("R8 wait 10", {30'd0, wait_states}, 32'd1);
    reg_write(8'h33, 8'h09); check("R8 wait 11", {30'd0, wait_states}, 32'd2);
    reg_write(8'h33, 8'h01); check("R8 wait 01", {30'd0, wait_states}, 32'd0);
    reg_write(8'h33, 8'hF6); check("R8 wait others", {30'd0, wait_states}, 32'd0);
  endtask

  task automatic test_cache();
    reg_write(8'h40, 8'h00); check("R9 cache on", {31'd0, ext_cache_en}, 32'd1);
    reg_write(8'h40, 8'hF7); check("R9 cache on other bits", {31'd0, ext_cache_en}, 32'd1);
    reg_write(8'h40, 8'h08); check("R9 cache off", {31'd0, ext_cache_en}, 32'd0);
  endtask

  task automatic test_same_cycle();
    reg_write(8'h2E, 8'h00);
    io_put(1'b0, 8'h2E);
    @(negedge clk);
    io_addr0 = 1'b1; io_wdata = 8'h03; io_wr = 1'b1;
    mem_addr = 20'hC0000; mem_rd = 1'b1;
    #1 check("R10 old enable same cycle", {30'd0, rd_int, rd_ext}, 32'b01);
    @(negedge clk);
    io_wr = 1'b0;
    #1 check("R10 new enable next cycle", {30'd0, rd_int, rd_ext}, 32'b10);
    mem_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_index_data();
    test_status();
    test_idle_bus();
    test_a20();
    test_small_slices();
    test_large_blocks();
    test_outside();
    test_reloc();
    test_wait();
    test_cache();
    test_same_cycle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule